// File: doc/BRIEF.md
# Prioritized Interrupt Status Controller

This block gathers the request lines of thirteen peripheral sources into a 32-bit pending-status word and pairs it with a 32-bit enable mask. The rising edge of a request line sets the status bit that belongs to the source, and its falling edge clears it. Every bit of the status word is also reachable from a word-wide register bus. Software reads it to find the cause of an interrupt and writes it to clear or force bits. The mask is read and written through the same bus.

From the status and mask the block derives a 3-bit processor priority level. The sources fall into three groups at levels 3, 5 and 6, placed at fixed and sparse bit positions. The output is the highest group level that has at least one pending, enabled member. A separate side input carries the DMA-enable bit of the storage controller's control register. Each write of that register copies the bit into the storage-DMA status position.

Top module: `irq_level_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the status word, the mask word, `ipl` and `bus_rdata` all become zero.
- R2: A rising edge on `src_req[i]` sets one status bit. Index 0 maps to bit 2, 1 to bit 3, 2 to bit 5, 3 to bit 7, 4 to bit 9, 5 to bit 10, 6 to bit 12, 7 to bit 17, 8 to bit 21, 9 to bit 23, 10 to bit 26, 11 to bit 27 and 12 to bit 28. The bit is visible one clock after the edge.
- R3: A falling edge on `src_req[i]` clears the status bit of that source one clock later.
- R4: When `dma_en_wr` is high, status bit 26 takes the value of `dma_en_val` one clock later. This takes priority over a same-cycle edge on line 10.
- R5: A bus write at word offset 0x7000 loads the status word and one at 0x7800 loads the mask word, all 32 bits. A bus read at either offset returns that word on `bus_rdata` one clock after `bus_rd`.
- R6: A source is pending only when both its status bit and its mask bit are 1 (mask 1 means enabled). With no pending mapped source, `ipl` is 0.
- R7: `ipl` is 6 if a source on indices 8 to 12 is pending. Otherwise it is 5 if index 7 is pending, otherwise 3 if a source on indices 0 to 6 is pending, otherwise 0. `ipl` follows the status and mask registers by one clock, so it is due two clocks after the line edge or bus write that caused the change.
- R8: When a status write and a line edge (or a side-input write) arrive in the same cycle, the hardware event decides its own bit. All other bits take the written value.
- R9: Bus writes to any offset other than 0x7000 and 0x7800 change nothing. Bus reads of such offsets return 0.
- R10: Status bits react to edges only. A line held high does not set its bit again after software has cleared it. The bit is set again only by the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 13 | Peripheral request lines, index mapping per R2 |
| dma_en_wr | input | 1 | Strobe: storage control register written this cycle |
| dma_en_val | input | 1 | DMA-enable bit carried by that write |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after `bus_rd` |
| ipl | output | 3 | Registered processor priority level |

## Verification
A line edge or side-input write shows in the status word one clock later, so a read issued in the next cycle returns it two clocks after the stimulus. The priority level is due two clocks after the line edge or the status or mask write that changed it. Read data is due one clock after the read strobe. The driver stamps every expected item with the cycle in which it falls due, counted from these register stages. The monitor compares items only in that cycle, half a clock after the edge. Same-cycle collisions between bus writes and hardware events are driven on purpose to check the per-bit priority.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  localparam int NUM_SRC  = 13;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 16;
  localparam int IPL_W    = 3;
  localparam int MIRROR_BIT = 26;

  localparam logic [ADDR_W-1:0] STATUS_OFS = 16'h7000;
  localparam logic [ADDR_W-1:0] MASK_OFS   = 16'h7800;

  localparam logic [IPL_W-1:0] IPL_NONE = 3'd0;
  localparam logic [IPL_W-1:0] IPL_LOW  = 3'd3;
  localparam logic [IPL_W-1:0] IPL_MID  = 3'd5;
  localparam logic [IPL_W-1:0] IPL_HIGH = 3'd6;

  // status bit position owned by each request line
  function automatic int unsigned src_pos(input int unsigned idx);
    case (idx)
      0:  return 2;
      1:  return 3;
      2:  return 5;
      3:  return 7;
      4:  return 9;
      5:  return 10;
      6:  return 12;
      7:  return 17;
      8:  return 21;
      9:  return 23;
      10: return 26;
      11: return 27;
      12: return 28;
      default: return 0;
    endcase
  endfunction

  // processor level of each request line
  function automatic logic [IPL_W-1:0] src_level(input int unsigned idx);
    if (idx <= 6)      return IPL_LOW;
    else if (idx == 7) return IPL_MID;
    else               return IPL_HIGH;
  endfunction

  // status bits that belong to one priority group
  function automatic logic [DATA_W-1:0] level_mask(input logic [IPL_W-1:0] lvl);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      if (src_level(i) == lvl) m[src_pos(i)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_line_events.sv
module irq_line_events
  import irq_level_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int WIDTH  = DATA_W,
  parameter int MIR_B  = MIRROR_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic             mirror_wr,
  input  logic             mirror_val,
  output logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] hw_clr
);

  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] fall;
  logic [WIDTH-1:0] line_set;
  logic [WIDTH-1:0] line_clr;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src_req;
  end

  assign rise = src_req & ~prev_q;
  assign fall = ~src_req & prev_q;

  // scatter per-line edges into their sparse status positions
  always_comb begin
    line_set = '0;
    line_clr = '0;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      line_set[src_pos(i)] = rise[i];
      line_clr[src_pos(i)] = fall[i];
    end
  end

  // the control-register mirror overrides the line edge on its bit
  always_comb begin
    hw_set = line_set;
    hw_clr = line_clr;
    if (mirror_wr) begin
      hw_set[MIR_B] = mirror_val;
      hw_clr[MIR_B] = ~mirror_val;
    end
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_level_pkg::*;
#(
  parameter int                WIDTH = DATA_W,
  parameter int                AW    = ADDR_W,
  parameter logic [ADDR_W-1:0] ST_OFS = STATUS_OFS,
  parameter logic [ADDR_W-1:0] MK_OFS = MASK_OFS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] hw_set,
  input  logic [WIDTH-1:0] hw_clr,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] status_r;
  logic [WIDTH-1:0] mask_r;
  logic [WIDTH-1:0] status_d;
  logic             hit_status;
  logic             hit_mask;

  assign hit_status = (bus_addr == ST_OFS);
  assign hit_mask   = (bus_addr == MK_OFS);

  // software value first, hardware events win per bit afterwards
  always_comb begin
    status_d = status_r;
    if (bus_wr && hit_status) status_d = bus_wdata;
    status_d = (status_d & ~hw_clr) | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_r <= '0;
      mask_r   <= '0;
      rdata_o  <= '0;
    end else begin
      status_r <= status_d;
      if (bus_wr && hit_mask) mask_r <= bus_wdata;
      if (bus_rd) begin
        if (hit_status)    rdata_o <= status_r;
        else if (hit_mask) rdata_o <= mask_r;
        else               rdata_o <= '0;
      end
    end
  end

  assign status_o = status_r;
  assign mask_o   = mask_r;

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_level_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [IPL_W-1:0] ipl_o
);

  localparam logic [WIDTH-1:0] GRP_HIGH = level_mask(IPL_HIGH);
  localparam logic [WIDTH-1:0] GRP_MID  = level_mask(IPL_MID);
  localparam logic [WIDTH-1:0] GRP_LOW  = level_mask(IPL_LOW);

  logic [WIDTH-1:0] pend;
  logic             any_high;
  logic             any_mid;
  logic             any_low;
  logic [IPL_W-1:0] lvl_d;

  assign pend     = status_i & mask_i;
  assign any_high = |(pend & GRP_HIGH);
  assign any_mid  = |(pend & GRP_MID);
  assign any_low  = |(pend & GRP_LOW);

  always_comb begin
    if (any_high)     lvl_d = IPL_HIGH;
    else if (any_mid) lvl_d = IPL_MID;
    else if (any_low) lvl_d = IPL_LOW;
    else              lvl_d = IPL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) ipl_o <= IPL_NONE;
    else     ipl_o <= lvl_d;
  end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               dma_en_wr,
  input  logic               dma_en_val,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [IPL_W-1:0]   ipl
);

  logic [DATA_W-1:0] hw_set;
  logic [DATA_W-1:0] hw_clr;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mask_q;

  irq_line_events #(
    .N_SRC (NUM_SRC),
    .WIDTH (DATA_W),
    .MIR_B (MIRROR_BIT)
  ) u_events (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .mirror_wr  (dma_en_wr),
    .mirror_val (dma_en_val),
    .hw_set     (hw_set),
    .hw_clr     (hw_clr)
  );

  irq_regfile #(
    .WIDTH  (DATA_W),
    .AW     (ADDR_W),
    .ST_OFS (STATUS_OFS),
    .MK_OFS (MASK_OFS)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_set    (hw_set),
    .hw_clr    (hw_clr),
    .status_o  (status_q),
    .mask_o    (mask_q),
    .rdata_o   (bus_rdata)
  );

  irq_level_enc #(
    .WIDTH (DATA_W)
  ) u_enc (
    .clk      (clk),
    .rst      (rst),
    .status_i (status_q),
    .mask_i   (mask_q),
    .ipl_o    (ipl)
  );

endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk
  import irq_level_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              dma_en_wr,
  input logic              dma_en_val,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IPL_W-1:0]  ipl,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q
);

  localparam logic [DATA_W-1:0] HIGH_BITS = level_mask(IPL_HIGH);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && ipl == IPL_NONE));

  // R4
  mirror_bit_chk: assert property (@(posedge clk) disable iff (rst)
    dma_en_wr |=> (status_q[MIRROR_BIT] == $past(dma_en_val)));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == MASK_OFS) |=> (mask_q == $past(bus_wdata)));

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) == '0) |=> (ipl == IPL_NONE));

  // R7
  high_level_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q & HIGH_BITS) != '0) |=> (ipl == IPL_HIGH));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != STATUS_OFS && bus_addr != MASK_OFS) |=> (bus_rdata == '0));

endmodule

bind irq_level_ctrl irq_level_chk chk_i (.*);

// File: tb/irq_level_ctrl_tb_top.sv
module irq_level_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_ST = 16'h7000;
  localparam logic [15:0] A_MK = 16'h7800;

  typedef struct {
    int          due;
    int          kind;   // 0 read data, 1 priority level
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] src_req = '0;
  logic        dma_en_wr = 1'b0;
  logic        dma_en_val = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  ipl;

  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  item_t sb_q[$];

  int pos_tbl[13] = '{2, 3, 5, 7, 9, 10, 12, 17, 21, 23, 26, 27, 28};
  int lvl_tbl[13] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

  irq_level_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .dma_en_wr  (dma_en_wr),
    .dma_en_val (dma_en_val),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ipl        (ipl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every item in the cycle it falls due
  always @(negedge clk) begin
    for (int k = sb_q.size() - 1; k >= 0; k--) begin
      if (sb_q[k].due <= cyc) begin
        logic [31:0] act;
        act = (sb_q[k].kind == 0) ? bus_rdata : {29'd0, ipl};
        n_cmp++;
        if (sb_q[k].due != cyc || act !== sb_q[k].exp) begin
          n_bad++;
          $display("FAIL %s: %s actual=%h expected=%h (cycle %0d)", sb_q[k].tag,
                   (sb_q[k].kind == 0) ? "rdata" : "ipl", act, sb_q[k].exp, cyc);
        end
        sb_q.delete(k);
      end
    end
  end

  task automatic push(input int off, input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = cyc + off; it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    push(1, 0, exp, tag);
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic ipl_now(input int exp, input string tag);
    push(1, 1, exp, tag);
    tick();
  endtask

  // drive a line and expect the level two clocks later
  task automatic line(input int idx, input logic v, input int exp_lvl, input string tag);
    src_req[idx] = v;
    push(2, 1, exp_lvl, tag);
    tick();
  endtask

  initial begin
    tick(); tick(); tick(); tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    rd(A_ST, 32'h0, "R1");
    rd(A_MK, 32'h0, "R1");
    ipl_now(0, "R1");

    // R6 masked source raises no level
    line(12, 1'b1, 0, "R6");
    tick();
    rd(A_ST, 32'h1000_0000, "R2");
    line(12, 1'b0, 0, "R6");
    tick();
    rd(A_ST, 32'h0, "R3");

    // R5 mask load and readback
    wr(A_MK, 32'hFFFF_FFFF);
    rd(A_MK, 32'hFFFF_FFFF, "R5");

    // R7 level ordering
    line(1, 1'b1, 3, "R7");
    tick();
    rd(A_ST, 32'h0000_0008, "R2");
    line(7, 1'b1, 5, "R7");
    tick();
    line(9, 1'b1, 6, "R7");
    tick();
    rd(A_ST, 32'h0082_0008, "R2");
    line(9, 1'b0, 5, "R3");
    tick();
    rd(A_ST, 32'h0002_0008, "R3");

    // R6 masking the serial bit drops to level 3
    push(2, 1, 3, "R6");
    wr(A_MK, 32'hFFFD_FFFF);
    tick();
    rd(A_MK, 32'hFFFD_FFFF, "R5");

    // R4 side input mirrors into bit 26
    dma_en_wr = 1'b1; dma_en_val = 1'b1;
    push(2, 1, 6, "R4");
    tick();
    dma_en_wr = 1'b0;
    tick();
    rd(A_ST, 32'h0402_0008, "R4");
    dma_en_wr = 1'b1; dma_en_val = 1'b0;
    push(2, 1, 3, "R4");
    tick();
    dma_en_wr = 1'b0;
    tick();
    rd(A_ST, 32'h0002_0008, "R4");

    // R4 side input beats a same-cycle edge on line 10
    src_req[10] = 1'b1; dma_en_wr = 1'b1; dma_en_val = 1'b0;
    tick();
    dma_en_wr = 1'b0;
    tick();
    rd(A_ST, 32'h0002_0008, "R4");
    src_req[10] = 1'b0;
    tick();

    // R8 rising edge beats a same-cycle status write; R10 held lines stay cleared
    src_req[3] = 1'b1;
    wr(A_ST, 32'h0000_0001);
    tick();
    rd(A_ST, 32'h0000_0081, "R8");
    ipl_now(3, "R8");

    // R8 falling edge beats a same-cycle status write
    src_req[3] = 1'b0;
    wr(A_ST, 32'hFFFF_FFFF);
    tick();
    rd(A_ST, 32'hFFFF_FF7F, "R8");
    ipl_now(6, "R8");

    // R9 unmapped offsets
    wr(16'h1234, 32'h0);
    wr(16'h7004, 32'h0);
    tick();
    rd(A_ST, 32'hFFFF_FF7F, "R9");
    rd(A_MK, 32'hFFFD_FFFF, "R9");
    rd(16'h1234, 32'h0, "R9");
    rd(16'h7004, 32'h0, "R9");

    // R10 held line does not set again after software clears it
    wr(A_ST, 32'h0);
    tick(); tick();
    rd(A_ST, 32'h0, "R10");
    ipl_now(0, "R10");
    src_req[1] = 1'b0;
    tick();
    line(1, 1'b1, 3, "R10");
    tick();
    rd(A_ST, 32'h0000_0008, "R10");

    // clean up, full mask, then sweep every line
    src_req = '0;
    tick();
    wr(A_ST, 32'h0);
    wr(A_MK, 32'hFFFF_FFFF);
    tick(); tick();
    for (int i = 0; i < 13; i++) begin
      line(i, 1'b1, lvl_tbl[i], "R2");
      rd(A_ST, 32'h1 << pos_tbl[i], "R2");
      tick();
      line(i, 1'b0, 0, "R3");
      rd(A_ST, 32'h0, "R3");
      tick();
    end

    tick(); tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule